// File: doc/BRIEF.md
# MMU Fault Syndrome Generator

This block stands between a processor's address-translation lookup and its exception logic. Every lookup presents an access address, the kind of access (load, store or instruction fetch), the outcome of the translation buffer search (hit, protection fault or miss) and the configuration and mode bits. The block first decides whether translation applies. On a hit it forwards the translated physical page and the entry's permission bits. When translation does not apply, it returns the page-aligned address unchanged with full permissions.

If a translated access faults, the block latches the complete faulting address and builds an exception status word. The status word records whether the fault was a protection fault or a miss, whether the access was a fetch or a data access, and whether it was a store. It then raises an MMU exception request, which stays up until the exception logic acknowledges it. A second fault that arrives while a request is still pending cannot be reported in the normal way. Instead the block raises a sticky fatal flag.

The translation buffer is not part of this block; its search result arrives on input ports. Exception vectoring is also outside the block.

Top module: `mmu_fault_syndrome`

## Requirements
- R1: After reset, `map_valid_o`, `map_page_o`, `map_perm_o`, `fault_req_o`, `fault_addr_o`, `fault_status_o` and `fatal_o` are all zero.
- R2: Translation applies only when `vm_mode_i` is 1, `cfg_mmu_present_i` is 1, and either `cfg_full_i` is 0 or `ext_mmu_i` is 1. In every other case the lookup is handled as a pass-through, whatever the value of `result_i`.
- R3: A pass-through lookup drives `map_valid_o` high for exactly one cycle, one cycle after `lkp_valid_i`. It also sets `map_page_o` to the address with its low PAGE_BITS bits cleared and `map_perm_o` to 3'b111 (bit 0 read, bit 1 write, bit 2 execute).
- R4: A translated lookup with `result_i` = 0 (hit) drives `map_valid_o` high one cycle later. `map_page_o` becomes (entry physical base + page-aligned address − entry virtual base) with its low PAGE_BITS bits cleared, and `map_perm_o` becomes `entry_perm_i`.
- R5: A translated lookup with `result_i` = 1 (protection) or 2 or 3 (miss) sets `fault_addr_o` to the full, unaligned address one cycle later.
- R6: On a fault, `fault_status_o` is 16 for a protection fault on a data access and 17 for a protection fault on a fetch. It is 18 for a miss on a data access and 19 for a miss on a fetch. `kind_i` is encoded as 0 load, 1 store, 2 fetch; the value 3 is treated as a load.
- R7: Bit 10 of `fault_status_o` is 1 exactly when the faulting access is a store (`kind_i` = 1).
- R8: `fault_req_o` rises one cycle after a fault lookup and stays high until a cycle with `exc_ack_i` high; it is low from the following cycle onward.
- R9: A fault lookup that arrives while `fault_req_o` is high sets `fatal_o` one cycle later. `fatal_o` stays set until reset. `fault_req_o`, `fault_addr_o` and `fault_status_o` are left unchanged.
- R10: While `lkp_valid_i` is low, none of the outputs change and `map_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_valid_i | input | 1 | Lookup strobe |
| addr_i | input | ADDR_W | Access address |
| kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| result_i | input | 2 | Lookup outcome: 0 hit, 1 protection, 2/3 miss |
| entry_vbase_i | input | ADDR_W | Virtual base of the matching entry |
| entry_pbase_i | input | ADDR_W | Physical base of the matching entry |
| entry_perm_i | input | 3 | Entry permissions {exec, write, read} |
| cfg_mmu_present_i | input | 1 | Primary configuration: MMU present |
| cfg_full_i | input | 1 | Primary configuration: extended configuration in force |
| ext_mmu_i | input | 1 | Extended configuration reports an MMU |
| vm_mode_i | input | 1 | Machine status virtual-mode bit |
| exc_ack_i | input | 1 | Exception logic accepts the pending request |
| map_valid_o | output | 1 | One-cycle pulse: mapping outputs updated |
| map_page_o | output | ADDR_W | Physical page address |
| map_perm_o | output | 3 | Granted permissions {exec, write, read} |
| fault_req_o | output | 1 | MMU exception request |
| fault_addr_o | output | ADDR_W | Faulting address |
| fault_status_o | output | STATUS_W | Exception status code |
| fatal_o | output | 1 | Sticky recursive-fault flag |

## Verification
Every result appears exactly one clock after the lookup strobe that caused it. That holds for the mapping pulse, the page and permission values, the fault request, the captured address and status, and the fatal flag. A request cleared by an acknowledge drops one clock after the acknowledge. The driver applies inputs on the falling edge. It queues the expected outcome of each lookup, and the monitor compares it on the next falling edge, when `map_valid_o` pulses or `fault_req_o` rises. Lookups that must produce nothing push nothing into the queue, so any unexpected output is found as an empty-queue pop. Hold, release and fatal behaviour are sampled at fixed falling edges after the acknowledge or the second fault.

// File: rtl/mfs_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the fault syndrome generator.
// Assumes a 2-bit access kind and a 2-bit lookup outcome.
package mfs_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        LU_HIT  = 2'd0,
        LU_PROT = 2'd1,
        LU_MISS = 2'd2
    } lu_result_e;

    localparam int CODE_PROT_BASE = 16;
    localparam int CODE_MISS_BIT  = 1;
    localparam int CODE_FETCH_BIT = 0;
    localparam int CODE_STORE_BIT = 10;
endpackage

// File: rtl/mfs_gate.sv
`timescale 1ns/1ps
// mfs_gate: decides whether address translation applies to a lookup.
// Assumes the configuration bits are static between lookups.
module mfs_gate (
    input  logic cfg_mmu_present_i,
    input  logic cfg_full_i,
    input  logic ext_mmu_i,
    input  logic vm_mode_i,
    output logic translate_o
);
    logic available;

    // Availability from the two configuration levels, then mode gating.
    always_comb begin
        available   = cfg_mmu_present_i && (!cfg_full_i || ext_mmu_i);
        translate_o = available && vm_mode_i;
    end
endmodule

// File: rtl/mfs_xlate.sv
`timescale 1ns/1ps
// mfs_xlate: forms the physical page and granted permissions.
// Assumes entry bases are supplied as page addresses; the result is
// page-aligned regardless.
module mfs_xlate #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic              translate_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] vbase_i,
    input  logic [ADDR_W-1:0] pbase_i,
    input  logic [2:0]        perm_i,
    output logic [ADDR_W-1:0] page_o,
    output logic [2:0]        perm_o
);
    localparam logic [ADDR_W-1:0] PAGE_MASK =
        {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

    logic [ADDR_W-1:0] vpage;
    logic [ADDR_W-1:0] shifted;

    // Rebase the virtual page onto the entry's physical base, or pass through.
    always_comb begin
        vpage   = addr_i & PAGE_MASK;
        shifted = (pbase_i + vpage - vbase_i) & PAGE_MASK;
        page_o  = translate_i ? shifted : vpage;
        perm_o  = translate_i ? perm_i : 3'b111;
    end
endmodule

// File: rtl/mfs_syndrome.sv
`timescale 1ns/1ps
// mfs_syndrome: encodes fault kind and access direction into a status word.
// Assumes STATUS_W > 10; result codes other than protection count as miss.
module mfs_syndrome #(
    parameter int STATUS_W = 16
) (
    input  logic [1:0]          kind_i,
    input  logic [1:0]          result_i,
    output logic [STATUS_W-1:0] code_o
);
    import mfs_pkg::*;

    // Build base code, then fold in miss, fetch and store indications.
    always_comb begin
        code_o = STATUS_W'(CODE_PROT_BASE);
        code_o[CODE_MISS_BIT]  = (result_i != LU_PROT);
        code_o[CODE_FETCH_BIT] = (kind_i == ACC_FETCH);
        code_o[CODE_STORE_BIT] = (kind_i == ACC_STORE);
    end
endmodule

// File: rtl/mmu_fault_syndrome.sv
`timescale 1ns/1ps
// mmu_fault_syndrome: registers mapping results, captures faults, holds the
// exception request until acknowledged and traps recursive faults.
// Assumes one lookup per strobe; all outputs are registered.
module mmu_fault_syndrome #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int STATUS_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lkp_valid_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [1:0]          kind_i,
    input  logic [1:0]          result_i,
    input  logic [ADDR_W-1:0]   entry_vbase_i,
    input  logic [ADDR_W-1:0]   entry_pbase_i,
    input  logic [2:0]          entry_perm_i,
    input  logic                cfg_mmu_present_i,
    input  logic                cfg_full_i,
    input  logic                ext_mmu_i,
    input  logic                vm_mode_i,
    input  logic                exc_ack_i,
    output logic                map_valid_o,
    output logic [ADDR_W-1:0]   map_page_o,
    output logic [2:0]          map_perm_o,
    output logic                fault_req_o,
    output logic [ADDR_W-1:0]   fault_addr_o,
    output logic [STATUS_W-1:0] fault_status_o,
    output logic                fatal_o
);
    import mfs_pkg::*;

    logic                translate;
    logic [ADDR_W-1:0]   page_next;
    logic [2:0]          perm_next;
    logic [STATUS_W-1:0] code_next;
    logic                is_fault;
    logic                is_map;

    mfs_gate u_gate (
        .cfg_mmu_present_i (cfg_mmu_present_i),
        .cfg_full_i        (cfg_full_i),
        .ext_mmu_i         (ext_mmu_i),
        .vm_mode_i         (vm_mode_i),
        .translate_o       (translate)
    );

    mfs_xlate #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_xlate (
        .translate_i (translate),
        .addr_i      (addr_i),
        .vbase_i     (entry_vbase_i),
        .pbase_i     (entry_pbase_i),
        .perm_i      (entry_perm_i),
        .page_o      (page_next),
        .perm_o      (perm_next)
    );

    mfs_syndrome #(.STATUS_W(STATUS_W)) u_syn (
        .kind_i   (kind_i),
        .result_i (result_i),
        .code_o   (code_next)
    );

    // Classify the current lookup as a mapping or a fault.
    always_comb begin
        is_fault = lkp_valid_i && translate && (result_i != LU_HIT);
        is_map   = lkp_valid_i && !(translate && (result_i != LU_HIT));
    end

    // Mapping result registers: one-cycle valid pulse, values held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_valid_o <= 1'b0;
            map_page_o  <= '0;
            map_perm_o  <= '0;
        end else begin
            map_valid_o <= is_map;
            if (is_map) begin
                map_page_o <= page_next;
                map_perm_o <= perm_next;
            end
        end
    end

    // Fault capture, request hold/release and recursive-fault trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_req_o    <= 1'b0;
            fault_addr_o   <= '0;
            fault_status_o <= '0;
            fatal_o        <= 1'b0;
        end else if (is_fault && fault_req_o) begin
            fatal_o <= 1'b1;
        end else if (is_fault) begin
            fault_req_o    <= 1'b1;
            fault_addr_o   <= addr_i;
            fault_status_o <= code_next;
        end else if (exc_ack_i) begin
            fault_req_o <= 1'b0;
        end
    end
endmodule

// File: rtl/mfs_checker.sv
`timescale 1ns/1ps
// mfs_checker: temporal properties of mmu_fault_syndrome, bound to the top.
module mfs_checker #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int STATUS_W  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lkp_valid_i,
    input logic [ADDR_W-1:0]   addr_i,
    input logic [1:0]          kind_i,
    input logic                cfg_mmu_present_i,
    input logic                cfg_full_i,
    input logic                ext_mmu_i,
    input logic                vm_mode_i,
    input logic                exc_ack_i,
    input logic                map_valid_o,
    input logic [ADDR_W-1:0]   map_page_o,
    input logic [2:0]          map_perm_o,
    input logic                fault_req_o,
    input logic [ADDR_W-1:0]   fault_addr_o,
    input logic [STATUS_W-1:0] fault_status_o,
    input logic                fatal_o
);
    localparam logic [ADDR_W-1:0] PMASK =
        {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};
    localparam logic [STATUS_W-1:0] FREE_BITS = STATUS_W'(16'h0403);
    localparam logic [STATUS_W-1:0] BASE_CODE = STATUS_W'(16);

    // R3: with translation gated off, the mapping is a pass-through.
    assert_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid_o && !($past(vm_mode_i) && $past(cfg_mmu_present_i)
                          && (!$past(cfg_full_i) || $past(ext_mmu_i))))
        |-> (map_perm_o == 3'b111 && map_page_o == ($past(addr_i) & PMASK)));

    // R6: status word only uses the base code and its three flag bits.
    assert_code_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req_o |-> ((fault_status_o & ~FREE_BITS) == BASE_CODE));

    // R7: store flag follows the kind of the faulting access.
    assert_store_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_req_o) |-> (fault_status_o[10] == ($past(kind_i) == 2'd1)));

    // R8: request holds until acknowledged.
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_req_o && !exc_ack_i) |=> fault_req_o);

    // R9: fatal flag is sticky.
    assert_fatal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> fatal_o);

    // R9: a recursive fault leaves the captured fault untouched.
    assert_capture_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_o) |-> ($stable(fault_addr_o) && $stable(fault_status_o)));

    // R10: no lookup, no mapping pulse and no new request.
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid_i |=> (!map_valid_o && !$rose(fault_req_o) && !$rose(fatal_o)));
endmodule

bind mmu_fault_syndrome mfs_checker #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .STATUS_W(STATUS_W)
) chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .lkp_valid_i       (lkp_valid_i),
    .addr_i            (addr_i),
    .kind_i            (kind_i),
    .cfg_mmu_present_i (cfg_mmu_present_i),
    .cfg_full_i        (cfg_full_i),
    .ext_mmu_i         (ext_mmu_i),
    .vm_mode_i         (vm_mode_i),
    .exc_ack_i         (exc_ack_i),
    .map_valid_o       (map_valid_o),
    .map_page_o        (map_page_o),
    .map_perm_o        (map_perm_o),
    .fault_req_o       (fault_req_o),
    .fault_addr_o      (fault_addr_o),
    .fault_status_o    (fault_status_o),
    .fatal_o           (fatal_o)
);

// File: tb/mmu_fault_syndrome_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results, the monitor
// compares them on the falling edge after each registered update.
module mmu_fault_syndrome_tb_top;
    localparam int AW = 32;
    localparam int PB = 12;
    localparam int SW = 16;
    localparam logic [AW-1:0] PMASK = {{(AW-PB){1'b1}}, {PB{1'b0}}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lkp_valid = 1'b0;
    logic [AW-1:0] addr = '0, vbase = '0, pbase = '0;
    logic [1:0] kind = 2'd0, res = 2'd0;
    logic [2:0] perm = 3'd0;
    logic present = 1'b0, full = 1'b0, ext = 1'b0, vm = 1'b0, ack = 1'b0;
    logic map_valid, fault_req, fatal;
    logic [AW-1:0] map_page, fault_addr;
    logic [2:0] map_perm;
    logic [SW-1:0] fault_status;

    typedef struct {
        bit            is_fault;
        logic [AW-1:0] page;
        logic [2:0]    perm;
        logic [AW-1:0] faddr;
        logic [SW-1:0] code;
        string         req;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;
    bit pending = 1'b0;
    logic prev_req = 1'b0;

    always #2 clk = ~clk;

    mmu_fault_syndrome #(.ADDR_W(AW), .PAGE_BITS(PB), .STATUS_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .lkp_valid_i(lkp_valid), .addr_i(addr),
        .kind_i(kind), .result_i(res), .entry_vbase_i(vbase),
        .entry_pbase_i(pbase), .entry_perm_i(perm),
        .cfg_mmu_present_i(present), .cfg_full_i(full), .ext_mmu_i(ext),
        .vm_mode_i(vm), .exc_ack_i(ack), .map_valid_o(map_valid),
        .map_page_o(map_page), .map_perm_o(map_perm), .fault_req_o(fault_req),
        .fault_addr_o(fault_addr), .fault_status_o(fault_status),
        .fatal_o(fatal)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Driver: apply one lookup and queue the outcome the requirements predict.
    task automatic lookup(input logic [AW-1:0] a, input logic [1:0] k,
                          input logic [1:0] r, input logic [AW-1:0] vb,
                          input logic [AW-1:0] pb, input logic [2:0] pm,
                          input string req);
        exp_t e;
        bit tr;
        @(negedge clk);
        addr = a; kind = k; res = r; vbase = vb; pbase = pb; perm = pm;
        lkp_valid = 1'b1;
        tr = vm && present && (!full || ext);
        e.req = req;
        e.faddr = '0; e.code = '0; e.page = '0; e.perm = '0;
        if (!tr || r == 2'd0) begin
            e.is_fault = 1'b0;
            e.page = tr ? (((a & PMASK) + pb - vb) & PMASK) : (a & PMASK);
            e.perm = tr ? pm : 3'b111;
            sb.push_back(e);
        end else if (!pending) begin
            e.is_fault = 1'b1;
            e.faddr = a;
            e.code = SW'(16) | ((r != 2'd1) ? SW'(2) : SW'(0))
                   | ((k == 2'd2) ? SW'(1) : SW'(0))
                   | ((k == 2'd1) ? SW'(1024) : SW'(0));
            sb.push_back(e);
            pending = 1'b1;
        end
        @(negedge clk);
        lkp_valid = 1'b0;
    endtask

    // Acknowledge the pending request and check release (R8).
    task automatic do_ack();
        @(negedge clk);
        chk(fault_req === 1'b1, "R8 held before ack", 64'(fault_req), 1);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(fault_req === 1'b0, "R8 released after ack", 64'(fault_req), 0);
        pending = 1'b0;
    endtask

    // Monitor: pop and compare on every mapping pulse and new request.
    always @(negedge clk) begin
        if (rst_n) begin
            if (map_valid || (fault_req && !prev_req)) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 unexpected output", 64'(map_valid), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (!e.is_fault) begin
                        chk(map_valid === 1'b1, e.req, 64'(map_valid), 1);
                        chk(map_page === e.page, e.req, 64'(map_page), 64'(e.page));
                        chk(map_perm === e.perm, e.req, 64'(map_perm), 64'(e.perm));
                    end else begin
                        chk(fault_req === 1'b1 && !map_valid, e.req,
                            64'(fault_req), 1);
                        chk(fault_addr === e.faddr, {e.req, " R5 addr"},
                            64'(fault_addr), 64'(e.faddr));
                        chk(fault_status === e.code, {e.req, " R6 R7 code"},
                            64'(fault_status), 64'(e.code));
                    end
                end
            end
            prev_req <= fault_req;
        end else begin
            prev_req <= 1'b0;
        end
    end

    task automatic check_reset_state(input string req);
        chk({map_valid, map_page, map_perm, fault_req, fault_addr,
             fault_status, fatal} === '0, req, 64'(fault_addr), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R1 reset state");
        rst_n = 1'b1;

        // R2/R3: no MMU present -> pass-through even with miss result.
        vm = 1; present = 0;
        lookup(32'h1234_5678, 2'd0, 2'd2, 32'h0, 32'h0, 3'b001, "R2 R3 absent");
        // R2: full config but extended word reports no MMU.
        present = 1; full = 1; ext = 0;
        lookup(32'hDEAD_BEEF, 2'd1, 2'd1, 32'h0, 32'h0, 3'b000, "R2 ext absent");
        // R2: available but virtual mode off.
        full = 0; vm = 0;
        lookup(32'h0000_0FFF, 2'd2, 2'd2, 32'h0, 32'h0, 3'b000, "R2 vm off");

        // R4: hits under both configuration routes.
        vm = 1;
        lookup(32'h4000_3ABC, 2'd0, 2'd0, 32'h4000_0000, 32'h8000_0000,
               3'b011, "R4 hit base");
        full = 1; ext = 1;
        lookup(32'h0001_2345, 2'd2, 2'd0, 32'h0001_0000, 32'h0000_5000,
               3'b100, "R4 hit ext");
        lookup(32'h0000_1000, 2'd1, 2'd0, 32'h0000_2000, 32'h0000_0000,
               3'b010, "R4 hit wrap");

        // R5/R6/R7/R8: every fault kind, each acknowledged.
        lookup(32'h1111_1111, 2'd0, 2'd1, 0, 0, 0, "R6 prot load");
        repeat (2) @(negedge clk);
        do_ack();
        lookup(32'h2222_2222, 2'd1, 2'd1, 0, 0, 0, "R7 prot store");
        do_ack();
        lookup(32'h3333_3333, 2'd2, 2'd1, 0, 0, 0, "R6 prot fetch");
        do_ack();
        lookup(32'h4444_4444, 2'd0, 2'd2, 0, 0, 0, "R6 miss load");
        do_ack();
        lookup(32'h5555_5555, 2'd1, 2'd2, 0, 0, 0, "R7 miss store");
        do_ack();
        lookup(32'h6666_6666, 2'd2, 2'd3, 0, 0, 0, "R6 miss fetch");
        do_ack();
        lookup(32'h7777_7777, 2'd3, 2'd2, 0, 0, 0, "R6 kind3 as load");
        do_ack();

        // R10: fault-like inputs without the strobe change nothing.
        @(negedge clk);
        addr = 32'h9999_9999; res = 2'd2; kind = 2'd1;
        repeat (2) @(negedge clk);
        chk(!map_valid && !fault_req && fault_addr == 32'h7777_7777,
            "R10 idle inputs", 64'(fault_addr), 64'h7777_7777);

        // R9: second fault while pending -> fatal, capture kept.
        lookup(32'hAAAA_0001, 2'd0, 2'd1, 0, 0, 0, "R9 first fault");
        lookup(32'hBBBB_0002, 2'd2, 2'd2, 0, 0, 0, "R9 second fault");
        chk(fatal === 1'b1, "R9 fatal set", 64'(fatal), 1);
        chk(fault_addr === 32'hAAAA_0001, "R9 addr kept",
            64'(fault_addr), 64'hAAAA_0001);
        chk(fault_status === SW'(16), "R9 code kept", 64'(fault_status), 16);
        chk(fault_req === 1'b1, "R9 req kept", 64'(fault_req), 1);
        do_ack();
        chk(fatal === 1'b1, "R9 fatal sticky", 64'(fatal), 1);

        chk(sb.size() == 0, "R3 R4 queue drained", 64'(sb.size()), 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R1 reset after fatal");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule